// File: doc/BRIEF.md
# Wired-Output Interrupt Cause Controller

This block gathers up to 32 interrupt sources into one wired interrupt line that goes to a parent interrupt controller. Each source has one bit in a cause register. The inputs pass through a synchronizer and then set their cause bits. A single control bit decides how every source is captured: either a bit is set on each cycle its input is high, or it is set only on a rising transition of the input.

Software works through a small register slave with a write strobe and a byte address. The read data is combinational from the address. Software can do four things:
- block or pass each source with a mask;
- clear pending bits by writing zeros to the cause register;
- retrigger a source by writing ones to a separate set-only register;
- store a message-signalled-interrupt disable bit, which has no effect on the wired output.

The output stays high while any pending bit is not masked.

Top module: `irq_cause_agg`

## Requirements
- R1: While reset is held, and right after it, the mask register (byte offset 0x10) reads all ones, and the cause register (0x00) and the control register (0x28) read zero. `irq_o` is low.
- R2: In level mode (control bit 3 = 0), a cause bit is set on every cycle its synchronized input is high. An input that rises before clock edge 1 shows in the cause register after edge 3, and not after edge 2. The bit stays set after the input falls.
- R3: In level mode, clearing a cause bit while its input is still high has no lasting effect, and the bit reads back as set.
- R4: In edge mode (control bit 3 = 1), a 0-to-1 transition of a synchronized input sets its cause bit. The bit stays set after the input falls, until software clears it.
- R5: In edge mode, an input that is held high does not set its cause bit again after software has cleared it.
- R6: A write to the cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: Writing 1 to a bit of the set-cause register (offset 0x08) sets the matching cause bit. Bits written as 0 have no effect. The set-cause register reads as zero.
- R8: `irq_o` is high exactly when (cause AND NOT mask) is non-zero. A mask bit of 1 blocks its source. The mask reads back as written.
- R9: Control bit 5 is stored and read back but does not change `irq_o`. All other control bits, apart from bits 3 and 5, read as zero.
- R10: When a hardware set and a software clear reach the same cause bit in the same cycle, the bit ends up set.
- R11: Reads of any offset other than 0x00, 0x08, 0x10 and 0x28 return zero, and writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| src_i | input | N_SRC | Asynchronous interrupt source inputs |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Wired interrupt to the parent controller |

## Verification
The capture logic is driven with the following patterns, each in both trigger modes:
- A pulse is applied and then released. This separates level-sensitive capture from edge-sensitive capture once software clears the bit.
- An input is held high across a clear. This separates a held level, which sets the bit again, from an already-seen edge, which does not.
- A clear is written while the hardware is setting the same bit. This shows which side wins.
- Sparse patterns are written into the cause, set-cause and mask registers. These show that the clear, set and block actions act bit by bit and do not act on the whole word.
- Writes are made to unmapped offsets, and the control register is written with its stored bit set. These show that neither changes the output.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W = 32;

  // byte offsets software depends on
  localparam int OFS_CAUSE = 'h00;
  localparam int OFS_SETC  = 'h08;
  localparam int OFS_MASK  = 'h10;
  localparam int OFS_CTRL  = 'h28;

  localparam int CTRL_EDGE_BIT = 3;
  localparam int CTRL_MSI_BIT  = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAUSE,
    SEL_SETC,
    SEL_MASK,
    SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] q;
      logic [W-1:0] d;
      if (s == 0) begin : g_first
        assign d = d_i;
      end else begin : g_next
        assign d = g_stage[s-1].q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end
  endgenerate

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/irq_cause_core.sv
module irq_cause_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  logic         edge_mode_i,
  input  logic         clr_we_i,
  input  logic         set_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cause_o,
  output logic [W-1:0] hw_set_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] cause_q;
  logic [W-1:0] cause_d;
  logic [W-1:0] hw_set;
  logic [W-1:0] keep_mask;
  logic [W-1:0] sw_set;
  logic         cause_en;

  // next-state: hardware set ORs in last, so it beats a same-cycle clear
  always_comb begin
    hw_set    = edge_mode_i ? (sync_i & ~prev_q) : sync_i;
    keep_mask = clr_we_i ? wdata_i : '1;
    sw_set    = set_we_i ? wdata_i : '0;
    cause_d   = (cause_q & keep_mask) | sw_set | hw_set;
    cause_en  = clr_we_i | set_we_i | (|hw_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_o  = cause_q;
  assign hw_set_o = hw_set;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_agg_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [W-1:0]      cause_i,
  output logic              clr_we_o,
  output logic              set_we_o,
  output logic [W-1:0]      mask_o,
  output logic              edge_mode_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e    sel;
  logic [W-1:0] mask_q, mask_d;
  logic         edge_q, edge_d;
  logic         msi_q, msi_d;
  logic         mask_en, ctrl_en;

  always_comb begin
    if      (addr_i == ADDR_W'(OFS_CAUSE)) sel = SEL_CAUSE;
    else if (addr_i == ADDR_W'(OFS_SETC))  sel = SEL_SETC;
    else if (addr_i == ADDR_W'(OFS_MASK))  sel = SEL_MASK;
    else if (addr_i == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
    else                                   sel = SEL_NONE;
  end

  always_comb begin
    clr_we_o = wr_en_i && (sel == SEL_CAUSE);
    set_we_o = wr_en_i && (sel == SEL_SETC);
    mask_en  = wr_en_i && (sel == SEL_MASK);
    ctrl_en  = wr_en_i && (sel == SEL_CTRL);
    mask_d   = wdata_i[W-1:0];
    edge_d   = wdata_i[CTRL_EDGE_BIT];
    msi_d    = wdata_i[CTRL_MSI_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
      msi_q  <= 1'b0;
    end else if (ctrl_en) begin
      edge_q <= edge_d;
      msi_q  <= msi_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CAUSE: rdata_o = DATA_W'(cause_i);
      SEL_MASK:  rdata_o = DATA_W'(mask_q);
      SEL_CTRL: begin
        rdata_o[CTRL_EDGE_BIT] = edge_q;
        rdata_o[CTRL_MSI_BIT]  = msi_q;
      end
      default:   rdata_o = '0;
    endcase
  end

  assign mask_o      = mask_q;
  assign edge_mode_o = edge_q;
endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
  import irq_agg_pkg::*;
#(
  parameter int N_SRC       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic             rst_sync_n;
  logic [N_SRC-1:0] src_sync;
  logic [N_SRC-1:0] cause_q;
  logic [N_SRC-1:0] hw_set;
  logic [N_SRC-1:0] mask_q;
  logic             edge_mode;
  logic             clr_we;
  logic             set_we;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_sync_bank #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  irq_cause_core #(.W(N_SRC)) u_core (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sync_i      (src_sync),
    .edge_mode_i (edge_mode),
    .clr_we_i    (clr_we),
    .set_we_i    (set_we),
    .wdata_i     (wdata_i[N_SRC-1:0]),
    .cause_o     (cause_q),
    .hw_set_o    (hw_set)
  );

  irq_regs #(.W(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .cause_i     (cause_q),
    .clr_we_o    (clr_we),
    .set_we_o    (set_we),
    .mask_o      (mask_q),
    .edge_mode_o (edge_mode),
    .rdata_o     (rdata_o)
  );

  assign irq_o = |(cause_q & ~mask_q);
endmodule

// File: rtl/irq_cause_agg_chk.sv
module irq_cause_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N_SRC-1:0]  wdata,
  input logic [N_SRC-1:0]  cause_q,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  hw_set,
  input logic              irq_o
);
  logic wr_cause, wr_setc, wr_unmapped;
  assign wr_cause    = wr_en && (addr == ADDR_W'(OFS_CAUSE));
  assign wr_setc     = wr_en && (addr == ADDR_W'(OFS_SETC));
  assign wr_unmapped = wr_en && (addr != ADDR_W'(OFS_CAUSE)) && (addr != ADDR_W'(OFS_SETC))
                       && (addr != ADDR_W'(OFS_MASK)) && (addr != ADDR_W'(OFS_CTRL));

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert ((&mask_q) && (cause_q == '0) && !irq_o);
    end
  end

  // R6
  clear_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cause |=> ((cause_q & ~$past(wdata) & ~$past(hw_set)) == '0));

  // R7
  setc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setc |=> ((cause_q & $past(wdata)) == $past(wdata)));

  // R10
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((cause_q & $past(hw_set)) == $past(hw_set)));

  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cause |=> (($past(cause_q) & ~cause_q) == '0));

  // R8
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_o);

  // R11
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> $stable(mask_q));
endmodule

bind irq_cause_agg irq_cause_agg_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en_i),
  .addr    (addr_i),
  .wdata   (wdata_i[N_SRC-1:0]),
  .cause_q (cause_q),
  .mask_q  (mask_q),
  .hw_set  (hw_set),
  .irq_o   (irq_o)
);

// File: tb/irq_cause_agg_test.sv
module irq_cause_agg_test;
  localparam logic [3:0] OP_WR  = 4'd0;
  localparam logic [3:0] OP_RD  = 4'd1;
  localparam logic [3:0] OP_SRC = 4'd2;
  localparam int NV = 29;

  // {op, requirement number, byte offset, data / expected read, expected irq}
  localparam logic [48:0] VEC [NV] = '{
    {OP_RD,  4'd1,  8'h10, 32'hFFFF_FFFF, 1'b0},  // R1 mask after reset
    {OP_RD,  4'd1,  8'h00, 32'h0000_0000, 1'b0},  // R1 cause after reset
    {OP_RD,  4'd1,  8'h28, 32'h0000_0000, 1'b0},  // R1 control after reset
    {OP_WR,  4'd8,  8'h10, 32'h0000_0000, 1'b0},
    {OP_SRC, 4'd2,  8'h00, 32'h0000_0005, 1'b0},
    {OP_RD,  4'd2,  8'h00, 32'h0000_0005, 1'b1},  // R2 level capture
    {OP_SRC, 4'd2,  8'h00, 32'h0000_0000, 1'b0},
    {OP_RD,  4'd2,  8'h00, 32'h0000_0005, 1'b1},  // R2 stays after input falls
    {OP_WR,  4'd6,  8'h00, 32'hFFFF_FFFE, 1'b0},
    {OP_RD,  4'd6,  8'h00, 32'h0000_0004, 1'b1},  // R6 bitwise clear
    {OP_WR,  4'd7,  8'h08, 32'h8000_0000, 1'b0},
    {OP_RD,  4'd7,  8'h00, 32'h8000_0004, 1'b1},  // R7 software set
    {OP_WR,  4'd7,  8'h08, 32'h0000_0000, 1'b0},
    {OP_RD,  4'd7,  8'h00, 32'h8000_0004, 1'b1},  // R7 zeros ignored
    {OP_RD,  4'd7,  8'h08, 32'h0000_0000, 1'b1},  // R7 reads zero
    {OP_WR,  4'd8,  8'h10, 32'hFFFF_FFFF, 1'b0},
    {OP_RD,  4'd8,  8'h00, 32'h8000_0004, 1'b0},  // R8 all masked
    {OP_WR,  4'd8,  8'h10, 32'h7FFF_FFFF, 1'b0},
    {OP_RD,  4'd8,  8'h10, 32'h7FFF_FFFF, 1'b1},  // R8 one bit open
    {OP_WR,  4'd9,  8'h28, 32'hFFFF_FFD7, 1'b0},
    {OP_RD,  4'd9,  8'h28, 32'h0000_0000, 1'b1},  // R9 other bits read zero
    {OP_WR,  4'd9,  8'h28, 32'h0000_0020, 1'b0},
    {OP_RD,  4'd9,  8'h28, 32'h0000_0020, 1'b1},  // R9 msi bit, irq unaffected
    {OP_WR,  4'd11, 8'h04, 32'hFFFF_FFFF, 1'b0},
    {OP_RD,  4'd11, 8'h04, 32'h0000_0000, 1'b1},  // R11 unmapped read
    {OP_RD,  4'd11, 8'h10, 32'h7FFF_FFFF, 1'b1},  // R11 write had no effect
    {OP_WR,  4'd6,  8'h00, 32'h0000_0000, 1'b0},
    {OP_RD,  4'd6,  8'h00, 32'h0000_0000, 1'b0},  // R6 clear all
    {OP_RD,  4'd11, 8'h3C, 32'h0000_0000, 1'b0}   // R11 unmapped read
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] src;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  irq_cause_agg uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int req, input logic [7:0] a, input logic [31:0] e, input logic ei);
    addr = a;
    #1;
    checks++;
    if (rdata !== e || irq !== ei) begin
      fails++;
      $display("FAIL R%0d addr=%h rdata=%h exp=%h irq=%b exp_irq=%b", req, a, rdata, e, irq, ei);
    end
  endtask

  task automatic drive_src(input logic [31:0] d);
    @(negedge clk);
    src = d;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      v = VEC[i];
      case (v[48:45])
        OP_WR:   wr(v[40:33], v[32:1]);
        OP_RD:   rd_chk(int'(v[44:41]), v[40:33], v[32:1], v[0]);
        default: drive_src(v[32:1]);
      endcase
    end

    // R4: edge mode capture holds after the input falls
    wr(8'h28, 32'h0000_0008);
    wr(8'h10, 32'h0000_0000);
    drive_src(32'h0000_0010);
    rd_chk(4, 8'h00, 32'h0000_0010, 1'b1);
    drive_src(32'h0000_0000);
    rd_chk(4, 8'h00, 32'h0000_0010, 1'b1);

    // R5: held-high input is not re-captured after clear in edge mode
    drive_src(32'h0000_0020);
    rd_chk(5, 8'h00, 32'h0000_0030, 1'b1);
    wr(8'h00, 32'h0000_0000);
    repeat (4) @(negedge clk);
    rd_chk(5, 8'h00, 32'h0000_0000, 1'b0);

    // R3 / R10: level mode with input high, clear loses to hardware set
    wr(8'h28, 32'h0000_0000);
    @(negedge clk);
    rd_chk(3, 8'h00, 32'h0000_0020, 1'b1);
    wr(8'h00, 32'h0000_0000);
    rd_chk(10, 8'h00, 32'h0000_0020, 1'b1);
    repeat (3) @(negedge clk);
    rd_chk(3, 8'h00, 32'h0000_0020, 1'b1);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    src = '0;
    rd_chk(1, 8'h10, 32'hFFFF_FFFF, 1'b0);
    rd_chk(1, 8'h00, 32'h0000_0000, 1'b0);
    rd_chk(1, 8'h28, 32'h0000_0000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: latency, input visible after the third edge, not the second
    wr(8'h10, 32'h0000_0000);
    @(negedge clk);
    src = 32'h0000_0001;
    repeat (2) @(negedge clk);
    rd_chk(2, 8'h00, 32'h0000_0000, 1'b0);
    @(negedge clk);
    rd_chk(2, 8'h00, 32'h0000_0001, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule